// File: doc/BRIEF.md
# Quad-Precision Floating-Point Divider

This block divides one IEEE binary128 value by another. Each operand and the result are 128 bits wide. The sign sits in bit 127, the biased exponent (bias 16383) in bits 126:112 and the fraction in bits 111:0. A caller presents both operands and pulses `start_i` while the block is idle. Some operand pairs have a fixed answer: a NaN operand, a zero, an infinity, or a pair of these. The block settles those at once from a fixed table, and each such case raises its own flag. Every other pair goes through an iterative significand divider. The result then has `done_o` set for a single cycle.

The iterative path works in stages. It first normalises any subnormal operand with a leading-zero count and subtracts the exponents. It then produces the quotient one bit per cycle with a restoring subtract, for 116 steps. Those steps cover the 113 significand bits plus the guard, round and sticky bits. The remainder left at the end is folded into sticky. Finally the block rounds to nearest with ties to even. A result past the largest exponent becomes a signed infinity. A small result is delivered as a subnormal, or as a signed zero when it lies below that range.

Top module: `qp_divider`

## Requirements
- R1: After reset, `res_o` is zero and `done_o`, `busy_o` and all five flag outputs are low.
- R2: If either operand is a NaN (exponent all ones, fraction nonzero), the result is the quiet NaN 0x7FFF8000_00000000_00000000_00000000 and `fl_nan_o` is raised. This case takes priority over every other case.
- R3: Zero divided by zero gives the quiet NaN of R2 and raises `fl_zdz_o`.
- R4: Infinity divided by infinity gives the quiet NaN of R2 and raises `fl_idi_o`.
- R5: A finite nonzero value divided by zero gives an infinity (exponent all ones, fraction zero) whose sign is the XOR of the operand signs, and raises `fl_divz_o`.
- R6: An infinity divided by any non-NaN, non-infinite value gives an infinity with the XOR sign. A finite value divided by an infinity gives a zero with the XOR sign. Zero divided by a finite nonzero value gives a zero with the XOR sign. None of these cases raises a flag.
- R7: A special case (R2 to R6) is answered in one cycle. `done_o` is high in the cycle right after the start cycle, and `busy_o` stays low.
- R8: A divide of two finite nonzero operands sets `busy_o` from the edge that accepts the start. `done_o` rises 117 clock edges after that accepting edge, and `busy_o` falls on the same edge.
- R9: The quotient of finite nonzero operands is correctly rounded to nearest, with ties going to an even fraction LSB.
- R10: Subnormal operands are normalised before the divide. A quotient below the normal range is returned as a subnormal. A quotient below half the smallest subnormal is returned as a signed zero, with no flag.
- R11: A rounded quotient whose exponent reaches 32767 or more gives an infinity with the XOR sign and raises `fl_ovf_o`.
- R12: `start_i` is ignored while `busy_o` is high. The running divide then finishes with its own result and latency.
- R13: `done_o` is high for exactly one cycle per operation. Flags are only high together with `done_o`, and at most one flag is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe, taken only while idle |
| opa_i | input | 128 | Dividend |
| opb_i | input | 128 | Divisor |
| res_o | output | 128 | Quotient, held until the next result |
| done_o | output | 1 | One-cycle result-valid pulse |
| busy_o | output | 1 | Iterative divide in progress |
| fl_nan_o | output | 1 | NaN operand flag, pulsed with done |
| fl_zdz_o | output | 1 | Zero-by-zero invalid flag, pulsed with done |
| fl_idi_o | output | 1 | Infinity-by-infinity invalid flag, pulsed with done |
| fl_divz_o | output | 1 | Divide-by-zero flag, pulsed with done |
| fl_ovf_o | output | 1 | Overflow-to-infinity flag, pulsed with done |

## Verification
A special-case result and its flag are due in the very next cycle after the start cycle. An iterative result is due 117 edges after the accepting edge. The bench drives and samples only on falling clock edges. It counts those edges from the start cycle until `done_o` appears, and compares the count with 1 or 118. Result, flags and count are all checked at that same sample. One more falling edge then confirms that `done_o` has dropped. In the busy-period test, a special-case start is injected mid-divide. If that start were wrongly accepted, `done_o` would appear early and the latency check would fail.

// File: rtl/qp_div_pkg.sv
package qp_div_pkg;

   // operand classes found by the unpack stage
   typedef enum logic [2:0] {
      K_ZERO,
      K_SUB,
      K_NORM,
      K_INF,
      K_NAN
   } opk_e;

   // sequencer states of the divider
   typedef enum logic [1:0] {
      ST_IDLE,
      ST_ITER,
      ST_FIN
   } seq_e;

endpackage

// File: rtl/qp_div_unpack.sv
module qp_div_unpack
   import qp_div_pkg::*;
#(
   parameter int EXP_W  = 15,
   parameter int FRAC_W = 112,
   localparam int W     = 1 + EXP_W + FRAC_W,
   localparam int MW    = FRAC_W + 1,
   localparam int XW    = EXP_W + 3
) (
   input  logic [W-1:0]         opnd_i,
   output opk_e                 kind_o,
   output logic                 sign_o,
   output logic [MW-1:0]        mant_o,
   output logic signed [XW-1:0] exp_o
);

   localparam int LZW = $clog2(MW + 1);

   logic [EXP_W-1:0]  efld;
   logic [FRAC_W-1:0] ffld;
   logic [EXP_W-1:0]  eff;
   logic [MW-1:0]     raw;
   logic [LZW-1:0]    lz;
   logic              seen;

   assign efld   = opnd_i[W-2 -: EXP_W];
   assign ffld   = opnd_i[FRAC_W-1:0];
   assign sign_o = opnd_i[W-1];
   assign raw    = {(efld != '0), ffld};

   always_comb begin
      if (efld == '1)      kind_o = (ffld == '0) ? K_INF : K_NAN;
      else if (efld == '0) kind_o = (ffld == '0) ? K_ZERO : K_SUB;
      else                 kind_o = K_NORM;
   end

   // leading-zero count over the significand with its hidden bit
   always_comb begin
      lz   = '0;
      seen = 1'b0;
      for (int i = MW - 1; i >= 0; i--) begin
         if (!seen && raw[i]) begin
            lz   = LZW'(MW - 1 - i);
            seen = 1'b1;
         end
      end
   end

   assign eff    = (efld == '0) ? EXP_W'(1) : efld;
   assign mant_o = raw << lz;
   assign exp_o  = $signed({3'b000, eff}) - $signed(XW'(lz));

endmodule

// File: rtl/qp_div_iter.sv
module qp_div_iter #(
   parameter int MW    = 113,
   parameter int STEPS = MW + 3
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             load_i,
   input  logic             step_i,
   input  logic [MW-1:0]    dvd_i,
   input  logic [MW-1:0]    dvs_i,
   output logic [STEPS-1:0] quo_o,
   output logic             rem_nz_o
);

   logic [MW:0]      rem_q;
   logic [MW-1:0]    dvs_q;
   logic [STEPS-1:0] quo_q;
   logic             ge;
   logic [MW:0]      diff;

   // one restoring step: trial subtract, keep it only when it does not go negative
   always_comb begin
      ge   = (rem_q >= {1'b0, dvs_q});
      diff = ge ? (rem_q - {1'b0, dvs_q}) : rem_q;
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         rem_q <= '0;
         dvs_q <= '0;
         quo_q <= '0;
      end else if (load_i) begin
         rem_q <= {1'b0, dvd_i};
         dvs_q <= dvs_i;
         quo_q <= '0;
      end else if (step_i) begin
         rem_q <= {diff[MW-1:0], 1'b0};
         quo_q <= {quo_q[STEPS-2:0], ge};
      end
   end

   assign quo_o    = quo_q;
   assign rem_nz_o = (rem_q != '0);

endmodule

// File: rtl/qp_div_round.sv
module qp_div_round #(
   parameter int EXP_W  = 15,
   parameter int FRAC_W = 112,
   localparam int W     = 1 + EXP_W + FRAC_W,
   localparam int MW    = FRAC_W + 1,
   localparam int STEPS = MW + 3,
   localparam int XW    = EXP_W + 3
) (
   input  logic                 sign_i,
   input  logic signed [XW-1:0] exp_i,
   input  logic [STEPS-1:0]     quo_i,
   input  logic                 rem_nz_i,
   output logic [W-1:0]         res_o,
   output logic                 ovf_o
);

   localparam int EW   = MW + 2;
   localparam int EMAX = (1 << EXP_W) - 1;

   if (STEPS != MW + 3) begin : g_bad_steps
      $error("quotient must carry exactly three extra bits");
   end

   logic [EW-1:0]         ext, shd;
   logic                  st0, lost, g, st, up;
   logic signed [XW-1:0]  e, ef;
   logic [XW-1:0]         sh;
   logic [MW-1:0]         m;
   logic [MW:0]           msum;
   logic [FRAC_W-1:0]     frac;

   always_comb begin
      // normalise the raw quotient so the leading one is at the top
      if (quo_i[STEPS-1]) begin
         ext = quo_i[STEPS-1:1];
         st0 = quo_i[0] | rem_nz_i;
         e   = exp_i;
      end else begin
         ext = quo_i[STEPS-2:0];
         st0 = rem_nz_i;
         e   = exp_i - $signed(XW'(1));
      end

      // push below-range values into subnormal position
      sh = (int'(e) > 0) ? '0 : XW'(1 - int'(e));
      if (int'(sh) >= EW) begin
         shd  = '0;
         lost = |ext;
      end else begin
         shd  = ext >> sh;
         lost = |(ext & ~({EW{1'b1}} << sh));
      end

      m    = shd[EW-1:2];
      g    = shd[1];
      st   = shd[0] | lost | st0;
      up   = g & (st | m[0]);
      msum = {1'b0, m} + (MW + 1)'(up);

      ovf_o = 1'b0;
      ef    = e;
      frac  = msum[FRAC_W-1:0];
      if (int'(e) > 0) begin
         if (msum[MW]) begin
            ef   = e + $signed(XW'(1));
            frac = msum[FRAC_W:1];
         end
         if (int'(ef) >= EMAX) begin
            ovf_o = 1'b1;
            res_o = {sign_i, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
         end else begin
            res_o = {sign_i, ef[EXP_W-1:0], frac};
         end
      end else begin
         // a carry out of the subnormal fraction lands on exponent one
         res_o = {sign_i, {(EXP_W-1){1'b0}}, msum[FRAC_W], msum[FRAC_W-1:0]};
      end
   end

endmodule

// File: rtl/qp_divider.sv
module qp_divider
   import qp_div_pkg::*;
#(
   parameter int EXP_W  = 15,
   parameter int FRAC_W = 112,
   localparam int W     = 1 + EXP_W + FRAC_W
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         start_i,
   input  logic [W-1:0] opa_i,
   input  logic [W-1:0] opb_i,
   output logic [W-1:0] res_o,
   output logic         done_o,
   output logic         busy_o,
   output logic         fl_nan_o,
   output logic         fl_zdz_o,
   output logic         fl_idi_o,
   output logic         fl_divz_o,
   output logic         fl_ovf_o
);

   localparam int MW    = FRAC_W + 1;
   localparam int STEPS = MW + 3;
   localparam int XW    = EXP_W + 3;
   localparam int BIAS  = (1 << (EXP_W - 1)) - 1;
   localparam int CW    = $clog2(STEPS + 1);

   localparam logic [W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

   if (EXP_W < 4 || EXP_W > 28) begin : g_bad_exp
      $error("EXP_W out of supported range");
   end
   if (FRAC_W < 4) begin : g_bad_frac
      $error("FRAC_W too small");
   end

   // operand unpack, one per operand
   opk_e                 kind [2];
   logic                 sgn  [2];
   logic [MW-1:0]        mant [2];
   logic signed [XW-1:0] xp   [2];

   for (genvar k = 0; k < 2; k++) begin : g_op
      qp_div_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unp (
         .opnd_i (k == 0 ? opa_i : opb_i),
         .kind_o (kind[k]),
         .sign_o (sgn[k]),
         .mant_o (mant[k]),
         .exp_o  (xp[k])
      );
   end

   // fixed table of special results; flag order: nan, zdz, idi, divz, ovf
   logic         sx, sp_hit;
   logic [W-1:0] sp_res;
   logic [4:0]   sp_fl;

   always_comb begin
      sx     = sgn[0] ^ sgn[1];
      sp_hit = 1'b1;
      sp_res = '0;
      sp_fl  = '0;
      if (kind[0] == K_NAN || kind[1] == K_NAN) begin
         sp_res = QNAN;
         sp_fl  = 5'b10000;
      end else if (kind[0] == K_ZERO && kind[1] == K_ZERO) begin
         sp_res = QNAN;
         sp_fl  = 5'b01000;
      end else if (kind[0] == K_INF && kind[1] == K_INF) begin
         sp_res = QNAN;
         sp_fl  = 5'b00100;
      end else if (kind[0] == K_INF) begin
         sp_res = {sx, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      end else if (kind[1] == K_ZERO) begin
         sp_res = {sx, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
         sp_fl  = 5'b00010;
      end else if (kind[1] == K_INF || kind[0] == K_ZERO) begin
         sp_res = {sx, {(W-1){1'b0}}};
      end else begin
         sp_hit = 1'b0;
      end
   end

   // sequencer
   seq_e                 st_q;
   logic [CW-1:0]        cnt_q;
   logic                 sgn_q;
   logic signed [XW-1:0] exp_q;
   logic [W-1:0]         res_q;
   logic                 done_q;
   logic [4:0]           fl_q;
   logic                 load, step;
   logic [STEPS-1:0]     quo;
   logic                 rem_nz;
   logic [W-1:0]         rnd_res;
   logic                 rnd_ovf;

   assign load = (st_q == ST_IDLE) && start_i && !sp_hit;
   assign step = (st_q == ST_ITER);

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         st_q   <= ST_IDLE;
         cnt_q  <= '0;
         sgn_q  <= 1'b0;
         exp_q  <= '0;
         res_q  <= '0;
         done_q <= 1'b0;
         fl_q   <= '0;
      end else begin
         done_q <= 1'b0;
         fl_q   <= '0;
         case (st_q)
            ST_IDLE: begin
               if (start_i) begin
                  if (sp_hit) begin
                     res_q  <= sp_res;
                     fl_q   <= sp_fl;
                     done_q <= 1'b1;
                  end else begin
                     st_q  <= ST_ITER;
                     cnt_q <= '0;
                     sgn_q <= sx;
                     exp_q <= xp[0] - xp[1] + $signed(XW'(BIAS));
                  end
               end
            end
            ST_ITER: begin
               cnt_q <= cnt_q + CW'(1);
               if (cnt_q == CW'(STEPS - 1)) st_q <= ST_FIN;
            end
            ST_FIN: begin
               res_q  <= rnd_res;
               fl_q   <= {4'b0000, rnd_ovf};
               done_q <= 1'b1;
               st_q   <= ST_IDLE;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   qp_div_iter #(.MW(MW), .STEPS(STEPS)) u_iter (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .load_i   (load),
      .step_i   (step),
      .dvd_i    (mant[0]),
      .dvs_i    (mant[1]),
      .quo_o    (quo),
      .rem_nz_o (rem_nz)
   );

   qp_div_round #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_round (
      .sign_i   (sgn_q),
      .exp_i    (exp_q),
      .quo_i    (quo),
      .rem_nz_i (rem_nz),
      .res_o    (rnd_res),
      .ovf_o    (rnd_ovf)
   );

   assign res_o     = res_q;
   assign done_o    = done_q;
   assign busy_o    = (st_q != ST_IDLE);
   assign fl_nan_o  = fl_q[4];
   assign fl_zdz_o  = fl_q[3];
   assign fl_idi_o  = fl_q[2];
   assign fl_divz_o = fl_q[1];
   assign fl_ovf_o  = fl_q[0];

endmodule

// File: rtl/qp_divider_chk.sv
module qp_divider_chk #(
   parameter int EXP_W  = 15,
   parameter int FRAC_W = 112,
   localparam int W     = 1 + EXP_W + FRAC_W
) (
   input logic         clk_i,
   input logic         rst_ni,
   input logic         start_i,
   input logic [W-1:0] res_o,
   input logic         done_o,
   input logic         busy_o,
   input logic         fl_nan_o,
   input logic         fl_zdz_o,
   input logic         fl_idi_o,
   input logic         fl_divz_o,
   input logic         fl_ovf_o
);

   localparam logic [W-1:0] QN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

   logic [4:0] fl;
   logic       is_inf;
   assign fl     = {fl_nan_o, fl_zdz_o, fl_idi_o, fl_divz_o, fl_ovf_o};
   assign is_inf = (res_o[W-2:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}});

   // R13
   flag_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(fl));

   // R13
   flag_with_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fl != '0) |-> done_o);

   // R8
   done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> !busy_o);

   // R8
   busy_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(busy_o) |-> done_o);

   // R7
   start_taken_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!busy_o && start_i) |=> (done_o || busy_o));

   // R2
   invalid_qnan_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fl_nan_o || fl_zdz_o || fl_idi_o) |-> (res_o == QN));

   // R5
   divz_inf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fl_divz_o |-> is_inf);

   // R11
   ovf_inf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fl_ovf_o |-> is_inf);

endmodule

bind qp_divider qp_divider_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .start_i   (start_i),
   .res_o     (res_o),
   .done_o    (done_o),
   .busy_o    (busy_o),
   .fl_nan_o  (fl_nan_o),
   .fl_zdz_o  (fl_zdz_o),
   .fl_idi_o  (fl_idi_o),
   .fl_divz_o (fl_divz_o),
   .fl_ovf_o  (fl_ovf_o)
);

// File: tb/qp_divider_test.sv
module qp_divider_test;
   timeunit 1ns;
   timeprecision 1ps;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [127:0] a = '0, b = '0;
   logic [127:0] res;
   logic         done, busy, f_nan, f_zdz, f_idi, f_divz, f_ovf;
   logic [4:0]   flags;
   int           n_chk = 0, n_err = 0;
   bit           finished = 1'b0;

   assign flags = {f_nan, f_zdz, f_idi, f_divz, f_ovf};

   always #2.5 clk = ~clk;

   qp_divider uut (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start), .opa_i(a), .opb_i(b),
      .res_o(res), .done_o(done), .busy_o(busy), .fl_nan_o(f_nan),
      .fl_zdz_o(f_zdz), .fl_idi_o(f_idi), .fl_divz_o(f_divz), .fl_ovf_o(f_ovf)
   );

   localparam logic [127:0] ONE    = {1'b0, 15'h3FFF, 112'h0};
   localparam logic [127:0] NONE   = {1'b1, 15'h3FFF, 112'h0};
   localparam logic [127:0] TWO    = {1'b0, 15'h4000, 112'h0};
   localparam logic [127:0] THREE  = {1'b0, 15'h4000, 4'h8, 108'h0};
   localparam logic [127:0] FIVE   = {1'b0, 15'h4001, 4'h4, 108'h0};
   localparam logic [127:0] SIX    = {1'b0, 15'h4001, 4'h8, 108'h0};
   localparam logic [127:0] HALF   = {1'b0, 15'h3FFE, 112'h0};
   localparam logic [127:0] MAXF   = {1'b0, 15'h7FFE, {112{1'b1}}};
   localparam logic [127:0] BIG    = {1'b0, 15'h7FFE, 112'h0};
   localparam logic [127:0] MINSUB = {1'b0, 15'h0, 111'h0, 1'b1};
   localparam logic [127:0] NMINSB = {1'b1, 15'h0, 111'h0, 1'b1};
   localparam logic [127:0] HSUB   = {1'b0, 15'h0, 4'h8, 108'h0};
   localparam logic [127:0] SNAN   = {1'b0, 15'h7FFF, 111'h0, 1'b1};
   localparam logic [127:0] QNAN   = {1'b0, 15'h7FFF, 1'b1, 111'h0};
   localparam logic [127:0] PINF   = {1'b0, 15'h7FFF, 112'h0};
   localparam logic [127:0] NINF   = {1'b1, 15'h7FFF, 112'h0};
   localparam logic [127:0] PZ     = 128'h0;
   localparam logic [127:0] NZ     = {1'b1, 127'h0};

   typedef struct packed {
      logic [127:0] a;
      logic [127:0] b;
      logic [127:0] q;
      logic [4:0]   fl;
      logic         sp;
      logic [3:0]   rq;
   } vec_t;

   // flag order in fl: nan, zdz, idi, divz, ovf
   localparam int NV = 24;
   localparam vec_t VEC [NV] = '{
      '{ONE,   ONE,   ONE,                                  5'b00000, 1'b0, 4'd9},  // R9
      '{SIX,   THREE, TWO,                                  5'b00000, 1'b0, 4'd9},  // R9
      '{ONE,   THREE, {1'b0, 15'h3FFD, {28{4'h5}}},         5'b00000, 1'b0, 4'd9},  // R9
      '{NONE,  THREE, {1'b1, 15'h3FFD, {28{4'h5}}},         5'b00000, 1'b0, 4'd9},  // R9
      '{TWO,   THREE, {1'b0, 15'h3FFE, {28{4'h5}}},         5'b00000, 1'b0, 4'd9},  // R9
      '{ONE,   FIVE,  {1'b0, 15'h3FFC, {27{4'h9}}, 4'hA},   5'b00000, 1'b0, 4'd9},  // R9 round up
      '{{1'b0, 15'h0001, 111'h0, 1'b1}, TWO, HSUB,          5'b00000, 1'b0, 4'd9},  // R9 tie, even kept
      '{{1'b0, 15'h0001, 110'h0, 2'b11}, TWO, {1'b0, 15'h0, 4'h8, 104'h0, 4'h2},
                                                            5'b00000, 1'b0, 4'd9},  // R9 tie, odd up
      '{MAXF,  HALF,  PINF,                                 5'b00001, 1'b0, 4'd11}, // R11
      '{NMINSB, BIG,  NZ,                                   5'b00000, 1'b0, 4'd10}, // R10 to zero
      '{MINSUB, MINSUB, ONE,                                5'b00000, 1'b0, 4'd10}, // R10
      '{HSUB,  ONE,   HSUB,                                 5'b00000, 1'b0, 4'd10}, // R10
      '{PZ,    PZ,    QNAN,                                 5'b01000, 1'b1, 4'd3},  // R3
      '{ONE,   PZ,    PINF,                                 5'b00010, 1'b1, 4'd5},  // R5
      '{NONE,  PZ,    NINF,                                 5'b00010, 1'b1, 4'd5},  // R5
      '{ONE,   PINF,  PZ,                                   5'b00000, 1'b1, 4'd6},  // R6
      '{ONE,   NINF,  NZ,                                   5'b00000, 1'b1, 4'd6},  // R6
      '{ONE,   SNAN,  QNAN,                                 5'b10000, 1'b1, 4'd2},  // R2
      '{SNAN,  PZ,    QNAN,                                 5'b10000, 1'b1, 4'd2},  // R2 priority
      '{PINF,  NINF,  QNAN,                                 5'b00100, 1'b1, 4'd4},  // R4
      '{NINF,  TWO,   NINF,                                 5'b00000, 1'b1, 4'd6},  // R6
      '{PZ,    FIVE,  PZ,                                   5'b00000, 1'b1, 4'd6},  // R6
      '{NZ,    NINF,  PZ,                                   5'b00000, 1'b1, 4'd6},  // R6
      '{PINF,  PZ,    PINF,                                 5'b00000, 1'b1, 4'd6}   // R6
   };

   task automatic chk(input string what, input logic [127:0] act, input logic [127:0] exp_v);
      n_chk++;
      if (act !== exp_v) begin
         n_err++;
         $display("FAIL %s: actual=%h expected=%h", what, act, exp_v);
      end
   endtask

   task automatic run_op(input logic [127:0] x, input logic [127:0] y,
                         output logic [127:0] r, output logic [4:0] f, output int lat);
      @(negedge clk);
      a = x;
      b = y;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      lat = 1;
      while (!done && lat < 400) begin
         @(negedge clk);
         lat++;
      end
      r = res;
      f = flags;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      logic [127:0] r;
      logic [4:0]   f;
      int           lat;

      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 result after reset", res, '0);
      chk("R1 done after reset", 128'(done), 128'(0));
      chk("R1 busy after reset", 128'(busy), 128'(0));
      chk("R1 flags after reset", 128'(flags), 128'(0));

      for (int i = 0; i < NV; i++) begin
         run_op(VEC[i].a, VEC[i].b, r, f, lat);
         chk($sformatf("R%0d result vec %0d", VEC[i].rq, i), r, VEC[i].q);
         chk($sformatf("R%0d flags vec %0d", VEC[i].rq, i), 128'(f), 128'(VEC[i].fl));
         // R7 (special) or R8 (iterative) latency
         chk($sformatf("R%0d latency vec %0d", VEC[i].sp ? 7 : 8, i),
             128'(lat), VEC[i].sp ? 128'(1) : 128'(118));
         @(negedge clk);
         // R13 done lasts one cycle
         chk($sformatf("R13 done drop vec %0d", i), 128'(done), 128'(0));
      end

      // R12 start ignored while busy
      @(negedge clk);
      a = ONE;
      b = THREE;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      lat = 1;
      chk("R8 busy during divide", 128'(busy), 128'(1));
      repeat (4) begin
         @(negedge clk);
         lat++;
      end
      a = PZ;
      b = PZ;
      start = 1'b1;
      @(negedge clk);
      lat++;
      start = 1'b0;
      while (!done && lat < 400) begin
         @(negedge clk);
         lat++;
      end
      chk("R12 latency with ignored start", 128'(lat), 128'(118));
      chk("R12 result with ignored start", res, {1'b0, 15'h3FFD, {28{4'h5}}});
      chk("R12 flags with ignored start", 128'(flags), 128'(0));
      chk("R8 busy low at done", 128'(busy), 128'(0));

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule